// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block answers configuration-space accesses for a PCI Ethernet function. It holds a type-0 header one byte at a time. An upstream bus engine decodes the configuration cycles and passes each access in as a single byte request on a valid/ready channel. A request carries an 8-bit register offset, a read/write flag and write data. Each accepted read returns one byte on a response channel. Writes update the header silently and give no response.

From the stored header the block drives four plain control outputs for the rest of the controller:
- an I/O decode enable;
- a 32-byte-aligned I/O window base;
- an expansion ROM enable;
- an expansion ROM base.

Identification values, the interrupt line, the ROM size and the reset bases are parameters. Any change to a base register reaches these outputs on the clock edge that accepts the write.

Back-pressure rules:
- A request is accepted on a rising edge where both `req_valid` and `req_ready` are high.
- `req_ready` is high when no response is pending, or when the pending response is taken in the same cycle.
- A read response stays valid, with stable data, until `rsp_ready` is seen high.
- Only one response is ever outstanding.

Top module: `pcicfg_responder`

## Requirements
- R1: Identification bytes read as follows:
  - offsets 0x00..0x03 read 0xEC, 0x10, 0x29, 0x80;
  - subsystem offsets 0x2C..0x2F read the same four bytes;
  - status 0x06/0x07 reads 0x00/0x02;
  - revision 0x08, programming interface 0x09 and subclass 0x0A read 0x00;
  - base class 0x0B reads 0x02;
  - interrupt pin 0x3D reads 0x01.
- R2: The command low byte (0x04) resets to 0x01 and keeps only bits 1:0 of a write. The high byte (0x05) reads 0x00 and ignores writes. `io_enable` equals command bit 0.
- R3: The I/O base register occupies 0x10..0x13 and resets to 0x00000341.
  - A write to 0x10 stores the data ANDed with 0xFC, with bit 0 then set.
  - A read of 0x10 returns stored bits 7:5 with bit 0 set.
  - Bytes 0x11..0x13 read back what was written.
- R4: `io_base` equals the low 16 bits of the I/O base register ANDed with 0xFFE0. It resets to 0x0340 and follows a write to any of its bytes from the next cycle on.
- R5: The ROM base register occupies 0x30..0x33 and resets to 0x000F8001, so `rom_enable`=1 and `rom_base`=0x000F8000.
  - A read of 0x30 returns only bit 0.
  - A read of 0x31 returns the stored byte ANDed with the size mask, ORed with 0x18. The size mask is 0xE0 for the default 8 KB ROM.
- R6: ROM base writes work byte by byte:
  - a write to 0x30 keeps only bit 0, which drives `rom_enable`;
  - a write to 0x31 is ANDed with the size mask;
  - writes to 0x32 and 0x33 are stored as given.
  `rom_base` is {byte3, byte2, byte1, 0x00}.
- R7: Offsets 0x0C..0x0F are plain read/write bytes that reset to 0x00.
- R8: The interrupt line (0x3C) reads the configured IRQ number (default 10). Writes to it are ignored.
- R9: Every offset not named above reads 0x00. Writes to such offsets change no readable byte and no output.
- R10: Handshake timing:
  - `req_ready` = !`rsp_valid` || `rsp_ready`;
  - an accepted read sets `rsp_valid` with its data on the next cycle;
  - while `rsp_valid` && !`rsp_ready`, the response data is held stable;
  - an accepted write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Configuration byte offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 8 | Read data |
| io_enable | output | 1 | I/O decode enabled |
| io_base | output | IO_BASE_W | 32-byte-aligned I/O window base |
| rom_enable | output | 1 | Expansion ROM decode enabled |
| rom_base | output | 32 | Expansion ROM base address |

## Verification
The register file is driven with three kinds of write data:
- all-ones bytes, which reveal every masked bit (command, I/O base byte 0, ROM bytes 0 and 1);
- distinct ordinary bytes, which show that plain storage and upper base bytes are kept intact;
- writes to the read-only interrupt line and to unused offsets, which must leave every output and readable byte unchanged.

Each of these is followed by read-back and output observation. Read traffic runs both with a free-flowing consumer and with a consumer that stalls for several cycles while a second read waits. The stalled case separates correct data holding and back-pressure from a response that is lost or overwritten.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int CFG_BYTE_W = 8;
  localparam int CFG_OFS_W  = 8;
  typedef logic [CFG_BYTE_W-1:0] cfg_byte_t;

  // byte offsets whose placement host software depends on
  localparam cfg_byte_t OFS_VID     = 8'h00;
  localparam cfg_byte_t OFS_DID     = 8'h02;
  localparam cfg_byte_t OFS_CMD     = 8'h04;
  localparam cfg_byte_t OFS_CMD_HI  = 8'h05;
  localparam cfg_byte_t OFS_STAT_HI = 8'h07;
  localparam cfg_byte_t OFS_CLASS   = 8'h0B;
  localparam cfg_byte_t OFS_SCR     = 8'h0C;
  localparam cfg_byte_t OFS_IOBAR   = 8'h10;
  localparam cfg_byte_t OFS_SUBSYS  = 8'h2C;
  localparam cfg_byte_t OFS_ROMBAR  = 8'h30;
  localparam cfg_byte_t OFS_INTLINE = 8'h3C;
  localparam cfg_byte_t OFS_INTPIN  = 8'h3D;

  localparam cfg_byte_t STATUS_HI_VAL = 8'h02; // medium select timing
  localparam cfg_byte_t CLASS_NET     = 8'h02;
  localparam cfg_byte_t INTPIN_A      = 8'h01;
  localparam cfg_byte_t ROM_FIXED_ONES = 8'h18;
  localparam logic [1:0] CMD_RESET    = 2'b01;

  // mask for ROM base byte 1: clears address bits below the ROM size
  function automatic cfg_byte_t rom_size_mask(input int size_log2);
    int pages;
    pages = 1 << (size_log2 - 8);
    return cfg_byte_t'((256 - pages) & 255);
  endfunction
endpackage

// File: rtl/pcicfg_io_bar.sv
module pcicfg_io_bar
  import pcicfg_pkg::*;
#(
  parameter int          IO_BASE_W   = 16,
  parameter logic [31:0] RESET_VALUE = 32'h0000_0341
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           lane,
  input  cfg_byte_t            wr_data,
  output cfg_byte_t            rd_data,
  output logic [IO_BASE_W-1:0] io_base
);
  localparam int LANES = 4;
  localparam logic [IO_BASE_W-1:0] ALIGN = ~IO_BASE_W'(31);

  logic [31:0] bar_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    cfg_byte_t next_byte;
    if (b == 0) begin : g_low
      assign next_byte = (wr_data & 8'hFC) | 8'h01;
    end else begin : g_up
      assign next_byte = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bar_q[b*8 +: 8] <= RESET_VALUE[b*8 +: 8];
      else if (wr_en && lane == 2'(b))
        bar_q[b*8 +: 8] <= next_byte;
    end
  end

  always_comb begin
    if (lane == 2'd0)
      rd_data = (bar_q[7:0] & 8'hE0) | 8'h01;
    else
      rd_data = bar_q[{lane, 3'b000} +: 8];
  end

  assign io_base = bar_q[IO_BASE_W-1:0] & ALIGN;
endmodule

// File: rtl/pcicfg_rom_bar.sv
module pcicfg_rom_bar
  import pcicfg_pkg::*;
#(
  parameter bit          PRESENT    = 1'b1,
  parameter int          SIZE_LOG2  = 13,
  parameter logic [31:0] RESET_BASE = 32'h000F_8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  lane,
  input  cfg_byte_t   wr_data,
  output cfg_byte_t   rd_data,
  output logic        rom_enable,
  output logic [31:0] rom_base
);
  localparam int        LANES     = 4;
  localparam cfg_byte_t SIZE_MASK = rom_size_mask(SIZE_LOG2);
  localparam logic [31:0] RESET_VALUE = PRESENT ?
      {RESET_BASE[31:16], RESET_BASE[15:8] & SIZE_MASK, 8'h01} : 32'h0;

  logic [31:0] rom_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    cfg_byte_t next_byte;
    if (b == 0) begin : g_en
      assign next_byte = wr_data & 8'h01;
    end else if (b == 1) begin : g_sz
      assign next_byte = wr_data & SIZE_MASK;
    end else begin : g_hi
      assign next_byte = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rom_q[b*8 +: 8] <= RESET_VALUE[b*8 +: 8];
      else if (wr_en && lane == 2'(b))
        rom_q[b*8 +: 8] <= next_byte;
    end
  end

  always_comb begin
    case (lane)
      2'd0:    rd_data = {7'b0, rom_q[0]};
      2'd1:    rd_data = (rom_q[15:8] & SIZE_MASK) | ROM_FIXED_ONES;
      default: rd_data = rom_q[{lane, 3'b000} +: 8];
    endcase
  end

  assign rom_enable = PRESENT && rom_q[0];
  assign rom_base   = {rom_q[31:8], 8'h00};
endmodule

// File: rtl/pcicfg_scratch.sv
module pcicfg_scratch
  import pcicfg_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_BYTES)-1:0] sel,
  input  cfg_byte_t                    wr_data,
  output cfg_byte_t                    rd_data
);
  localparam int SEL_W = $clog2(NUM_BYTES);

  cfg_byte_t mem_q [NUM_BYTES];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[i] <= '0;
      else if (wr_en && sel == SEL_W'(i))
        mem_q[i] <= wr_data;
    end
  end

  assign rd_data = mem_q[sel];
endmodule

// File: rtl/pcicfg_responder.sv
module pcicfg_responder
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h10EC,
  parameter logic [15:0] DEVICE_ID     = 16'h8029,
  parameter logic [7:0]  IRQ_LINE      = 8'd10,
  parameter int          IO_BASE_W     = 16,
  parameter logic [31:0] IO_BASE_RESET = 32'h0000_0340,
  parameter bit          ROM_PRESENT   = 1'b1,
  parameter int          ROM_SIZE_LOG2 = 13,
  parameter logic [31:0] ROM_BASE_RESET = 32'h000F_8000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [7:0]           req_offset,
  input  logic [7:0]           req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [7:0]           rsp_data,
  output logic                 io_enable,
  output logic [IO_BASE_W-1:0] io_base,
  output logic                 rom_enable,
  output logic [31:0]          rom_base
);
  localparam int SCR_BYTES = 4;

  logic       acc, wr_acc, rd_acc;
  logic [5:0] dword;
  logic [1:0] lane;
  logic       hit_scr, hit_iobar, hit_rom;
  logic [1:0] cmd_q;
  cfg_byte_t  scr_rd, iobar_rd, rom_rd, rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;
  assign dword     = req_offset[7:2];
  assign lane      = req_offset[1:0];
  assign hit_scr   = dword == OFS_SCR[7:2];
  assign hit_iobar = dword == OFS_IOBAR[7:2];
  assign hit_rom   = dword == OFS_ROMBAR[7:2];

  // command register: only I/O and memory enable bits are writable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd_q <= CMD_RESET;
    else if (wr_acc && req_offset == OFS_CMD)
      cmd_q <= req_wdata[1:0];
  end
  assign io_enable = cmd_q[0];

  pcicfg_scratch #(.NUM_BYTES(SCR_BYTES)) u_scratch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc && hit_scr), .sel(lane),
    .wr_data(req_wdata), .rd_data(scr_rd)
  );

  pcicfg_io_bar #(
    .IO_BASE_W(IO_BASE_W), .RESET_VALUE(IO_BASE_RESET | 32'h1)
  ) u_io_bar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc && hit_iobar), .lane(lane),
    .wr_data(req_wdata), .rd_data(iobar_rd), .io_base(io_base)
  );

  pcicfg_rom_bar #(
    .PRESENT(ROM_PRESENT), .SIZE_LOG2(ROM_SIZE_LOG2), .RESET_BASE(ROM_BASE_RESET)
  ) u_rom_bar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc && hit_rom), .lane(lane),
    .wr_data(req_wdata), .rd_data(rom_rd), .rom_enable(rom_enable),
    .rom_base(rom_base)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_scr)        rd_mux = scr_rd;
    else if (hit_iobar) rd_mux = iobar_rd;
    else if (hit_rom)   rd_mux = rom_rd;
    else begin
      case (req_offset)
        OFS_VID:                 rd_mux = VENDOR_ID[7:0];
        OFS_VID | 8'h01:         rd_mux = VENDOR_ID[15:8];
        OFS_DID:                 rd_mux = DEVICE_ID[7:0];
        OFS_DID | 8'h01:         rd_mux = DEVICE_ID[15:8];
        OFS_CMD:                 rd_mux = {6'b0, cmd_q};
        OFS_STAT_HI:             rd_mux = STATUS_HI_VAL;
        OFS_CLASS:               rd_mux = CLASS_NET;
        OFS_SUBSYS:              rd_mux = VENDOR_ID[7:0];
        OFS_SUBSYS | 8'h01:      rd_mux = VENDOR_ID[15:8];
        OFS_SUBSYS | 8'h02:      rd_mux = DEVICE_ID[7:0];
        OFS_SUBSYS | 8'h03:      rd_mux = DEVICE_ID[15:8];
        OFS_INTLINE:             rd_mux = IRQ_LINE;
        OFS_INTPIN:              rd_mux = INTPIN_A;
        default:                 rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcicfg_responder_chk.sv
module pcicfg_responder_chk #(
  parameter logic [15:0] VENDOR_ID   = 16'h10EC,
  parameter logic [7:0]  IRQ_LINE    = 8'd10,
  parameter bit          ROM_PRESENT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [7:0]  req_offset,
  input logic [7:0]  req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic        io_enable,
  input logic [15:0] io_base,
  input logic        rom_enable
);
  logic rd_acc, wr_acc;
  assign rd_acc = req_valid && req_ready && !req_write;
  assign wr_acc = req_valid && req_ready && req_write;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R10
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  // R10
  write_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !rsp_valid);
  // R2
  cmd_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && req_offset == 8'h04 |=> io_enable == $past(req_wdata[0]));
  // R4
  io_base_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && req_offset == 8'h10 |=> io_base[7:0] == ($past(req_wdata) & 8'hE0));
  // R4
  io_base_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && req_offset == 8'h11 |=> io_base[15:8] == $past(req_wdata));
  // R6
  rom_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && req_offset == 8'h30 |=> rom_enable == (ROM_PRESENT && $past(req_wdata[0])));
  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_offset == 8'h3C |=> rsp_data == IRQ_LINE);
  // R1
  vendor_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_offset == 8'h00 |=> rsp_data == VENDOR_ID[7:0]);
  // R9
  unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && req_offset >= 8'h40 |=> rsp_data == 8'h00);
endmodule

bind pcicfg_responder pcicfg_responder_chk #(
  .VENDOR_ID(VENDOR_ID), .IRQ_LINE(IRQ_LINE), .ROM_PRESENT(ROM_PRESENT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .io_enable(io_enable), .io_base(io_base[15:0]), .rom_enable(rom_enable)
);

// File: tb/test_pcicfg_responder.sv
module test_pcicfg_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_offset = '0, req_wdata = '0;
  logic req_ready, rsp_valid, io_enable, rom_enable;
  logic [7:0] rsp_data;
  logic [15:0] io_base;
  logic [31:0] rom_base;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  pcicfg_responder i_pcicfg_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .io_enable(io_enable), .io_base(io_base), .rom_enable(rom_enable),
    .rom_base(rom_base)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_cmd;
  logic [7:0] m_bar [4];
  logic [7:0] m_rom [4];
  logic [7:0] m_scr [4];
  logic       m_rv;
  logic [7:0] m_rd;

  function automatic logic [7:0] m_read(input logic [7:0] o);
    if (o >= 8'h0C && o <= 8'h0F) return m_scr[o - 8'h0C];
    if (o >= 8'h10 && o <= 8'h13) return (o == 8'h10) ? ((m_bar[0] & 8'hE0) | 8'h01) : m_bar[o - 8'h10];
    if (o == 8'h30) return m_rom[0] & 8'h01;
    if (o == 8'h31) return (m_rom[1] & 8'hE0) | 8'h18;
    if (o == 8'h32 || o == 8'h33) return m_rom[o - 8'h30];
    case (o)
      8'h00, 8'h2C: return 8'hEC;
      8'h01, 8'h2D: return 8'h10;
      8'h02, 8'h2E: return 8'h29;
      8'h03, 8'h2F: return 8'h80;
      8'h04: return m_cmd;
      8'h07, 8'h0B: return 8'h02;
      8'h3C: return 8'd10;
      8'h3D: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd <= 8'h01;
      m_bar[0] <= 8'h41; m_bar[1] <= 8'h03; m_bar[2] <= 8'h00; m_bar[3] <= 8'h00;
      m_rom[0] <= 8'h01; m_rom[1] <= 8'h80; m_rom[2] <= 8'h0F; m_rom[3] <= 8'h00;
      for (int i = 0; i < 4; i++) m_scr[i] <= 8'h00;
      m_rv <= 1'b0;
      m_rd <= 8'h00;
    end else begin
      if (req_valid && (!m_rv || rsp_ready)) begin
        if (!req_write) begin
          m_rv <= 1'b1;
          m_rd <= m_read(req_offset);
        end else begin
          m_rv <= 1'b0;
          case (req_offset)
            8'h04: m_cmd <= req_wdata & 8'h03;
            8'h0C, 8'h0D, 8'h0E, 8'h0F: m_scr[req_offset - 8'h0C] <= req_wdata;
            8'h10: m_bar[0] <= (req_wdata & 8'hFC) | 8'h01;
            8'h11, 8'h12, 8'h13: m_bar[req_offset - 8'h10] <= req_wdata;
            8'h30: m_rom[0] <= req_wdata & 8'h01;
            8'h31: m_rom[1] <= req_wdata & 8'hE0;
            8'h32, 8'h33: m_rom[req_offset - 8'h30] <= req_wdata;
            default: ;
          endcase
        end
      end else if (rsp_ready) begin
        m_rv <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 model io_enable", 32'(io_enable), 32'(m_cmd[0]));
      check("R4 model io_base", 32'(io_base), {16'h0, m_bar[1], m_bar[0] & 8'hE0});
      check("R6 model rom_enable", 32'(rom_enable), 32'(m_rom[0][0]));
      check("R6 model rom_base", rom_base, {m_rom[3], m_rom[2], m_rom[1], 8'h00});
      check("R10 model req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
      check("R10 model rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) check("R10 model rsp_data", 32'(rsp_data), 32'(m_rd));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic do_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {23'h0, rsp_valid, rsp_data}, {23'h0, 1'b1, exp});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R2 reset io_enable", 32'(io_enable), 32'd1);
    check("R4 reset io_base", 32'(io_base), 32'h0340);
    check("R5 reset rom_enable", 32'(rom_enable), 32'd1);
    check("R5 reset rom_base", rom_base, 32'h000F8000);
    check("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);

    // R1 identification
    do_read(8'h00, 8'hEC, "R1 vid lo");
    do_read(8'h01, 8'h10, "R1 vid hi");
    do_read(8'h02, 8'h29, "R1 did lo");
    do_read(8'h03, 8'h80, "R1 did hi");
    do_read(8'h2C, 8'hEC, "R1 ssvid lo");
    do_read(8'h2F, 8'h80, "R1 ssid hi");
    do_read(8'h07, 8'h02, "R1 status hi");
    do_read(8'h08, 8'h00, "R1 revision");
    do_read(8'h0B, 8'h02, "R1 class");
    do_read(8'h0A, 8'h00, "R1 subclass");
    do_read(8'h3D, 8'h01, "R1 int pin");

    // R2 command masking
    do_read(8'h04, 8'h01, "R2 cmd reset");
    do_write(8'h04, 8'hFF);
    do_read(8'h04, 8'h03, "R2 cmd masked");
    check("R2 io_enable set", 32'(io_enable), 32'd1);
    do_write(8'h04, 8'hFE);
    check("R2 io_enable clear", 32'(io_enable), 32'd0);
    do_write(8'h05, 8'hFF);
    do_read(8'h05, 8'h00, "R2 cmd hi ignored");

    // R3 / R4 I/O base
    do_read(8'h10, 8'h41, "R3 bar0 reset b0");
    do_read(8'h11, 8'h03, "R3 bar0 reset b1");
    do_write(8'h10, 8'hFF);
    do_read(8'h10, 8'hE1, "R3 bar0 b0 masked");
    check("R4 io_base after b0", 32'(io_base), 32'h03E0);
    do_write(8'h11, 8'h12);
    check("R4 io_base after b1", 32'(io_base), 32'h12E0);
    do_write(8'h13, 8'h56);
    do_read(8'h13, 8'h56, "R3 bar0 b3");
    check("R4 io_base upper ignored", 32'(io_base), 32'h12E0);

    // R5 / R6 ROM base
    do_read(8'h30, 8'h01, "R5 rom b0 reset");
    do_read(8'h31, 8'h98, "R5 rom b1 reset");
    do_read(8'h32, 8'h0F, "R5 rom b2 reset");
    do_write(8'h30, 8'hFE);
    check("R6 rom disabled", 32'(rom_enable), 32'd0);
    do_read(8'h30, 8'h00, "R6 rom b0 only bit0");
    do_write(8'h31, 8'hFF);
    do_read(8'h31, 8'hF8, "R6 rom b1 masked");
    check("R6 rom_base b1", rom_base, 32'h000FE000);
    do_write(8'h30, 8'h01);
    do_write(8'h33, 8'hAB);
    check("R6 rom enabled", 32'(rom_enable), 32'd1);
    check("R6 rom_base b3", rom_base, 32'hAB0FE000);

    // R7 scratch bytes
    for (int i = 0; i < 4; i++) do_write(8'(8'h0C + i), 8'(8'hA5 ^ (i * 8'h11)));
    for (int i = 0; i < 4; i++) do_read(8'(8'h0C + i), 8'(8'hA5 ^ (i * 8'h11)), "R7 scratch");

    // R8 interrupt line
    do_read(8'h3C, 8'd10, "R8 irq reset");
    do_write(8'h3C, 8'h05);
    do_read(8'h3C, 8'd10, "R8 irq write ignored");

    // R9 unimplemented offsets
    do_write(8'h40, 8'h77);
    do_read(8'h40, 8'h00, "R9 unimpl 0x40");
    do_write(8'h01, 8'h55);
    do_read(8'h01, 8'h10, "R9 vid write ignored");
    do_write(8'hFF, 8'hFF);
    do_read(8'hFF, 8'h00, "R9 unimpl 0xFF");
    check("R9 io_base untouched", 32'(io_base), 32'h12E0);
    check("R9 rom_base untouched", rom_base, 32'hAB0FE000);

    // R10 stalled consumer
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_offset = 8'h00;
    @(negedge clk);
    req_offset = 8'h02; // second read must wait
    for (int k = 0; k < 3; k++) begin
      check("R10 stall valid", 32'(rsp_valid), 32'd1);
      check("R10 stall data", 32'(rsp_data), 32'hEC);
      check("R10 stall ready low", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second read", {23'h0, rsp_valid, rsp_data}, {23'h0, 1'b1, 8'h29});
    @(negedge clk);
    check("R10 drained", 32'(rsp_valid), 32'd0);
    do_write(8'h0C, 8'h00);
    check("R10 write no response", 32'(rsp_valid), 32'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule